// File: doc/BRIEF.md
# Critical-Word-First Burst Address Sequencer

This block produces the column word addresses of one memory burst, one address per beat. A burst begins with a start pulse that carries the column address of the word the requester needs most. That word always goes out on the first beat. The remaining words of the aligned burst block follow in one of two orders. In wrap-around sequential order, a beat counter is added to the in-burst offset and any carry out of the block is dropped. In interleaved order, the beat counter is XORed into the offset.

The burst length is 4 or 8 beats, and the order is chosen per burst when the burst starts. A downstream consumer paces the beats with a ready signal. A typical use is to split a 64-byte cache-line writeback into eight 8-byte beats, each one bus width wide. A power failure during such a transfer can then tear the line only between beats, and the requested word has already been sent first.

Top module: `bsq_burst_seq`

## Requirements
- R1: The first beat after an accepted start carries `beat_o` = 0 and `col_o` equal to the requested column address.
- R2: With `ilv_i` = 0 (sequential), the in-burst offset of beat i is (start offset + i) modulo the burst length.
- R3: The column bits above the in-burst offset (above bit 1 for 4 beats, above bit 2 for 8 beats) equal those of the requested address on every beat. A carry out of the offset never reaches them.
- R4: With `ilv_i` = 1 (interleaved), the in-burst offset of beat i is the start offset XOR i.
- R5: With `bl8_i` = 1 a burst has 8 beats, and with `bl8_i` = 0 it has 4 beats. `last_o` is high exactly on the beat with `beat_o` = burst length − 1.
- R6: A beat moves on only in a cycle where `vld_o` and `rdy_i` are both high. While `rdy_i` is low, `col_o` and `beat_o` hold their values.
- R7: A start is taken only while `vld_o` is low. A start pulse during a burst is ignored, and so are changes to `bl8_i` or `ilv_i` during a burst. `vld_o` is low in the cycle after the last beat is accepted.
- R8: A synchronous active-high `rst` drives `vld_o` low and `beat_o` and `last_o` to 0, and a start held during reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, taken when idle |
| start_col_i | input | COL_W | Requested (critical) column word address |
| bl8_i | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential wrap order |
| rdy_i | input | 1 | Downstream accepts the current beat |
| col_o | output | COL_W | Column word address of the current beat |
| vld_o | output | 1 | Beat valid |
| beat_o | output | 3 | Index of the current beat within the burst |
| last_o | output | 1 | Current beat is the final one |

## Verification
The hardest case to reach from the ports is a start offset near the top of the burst block with the upper column bits all ones. Only that combination shows whether the wrap drops the carry or lets it ripple into the upper bits. The bench sweeps every start offset for both lengths and both orders, with upper bits drawn at random and forced to all ones. While a burst is running, it also pulses start and toggles the mode inputs in the cycle right after acceptance, which shows that the captured settings stay fixed. Random ready stalls keep some beats waiting for several cycles, including the last beat.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    localparam int BEAT_W = 3;
    localparam int OFS_W  = 3;
    localparam int BL4_LOG = 2;

    typedef enum logic { BLEN_4 = 1'b0, BLEN_8 = 1'b1 } blen_e;
    typedef enum logic { ORD_SEQ = 1'b0, ORD_ILV = 1'b1 } order_e;
endpackage

// File: rtl/bsq_last_det.sv
module bsq_last_det
    import bsq_pkg::*;
(
    input  logic              active_i,
    input  blen_e             blen_i,
    input  logic [BEAT_W-1:0] cnt_i,
    output logic              last_o
);
    logic [BEAT_W-1:0] final_idx;

    always_comb begin
        final_idx = (blen_i == BLEN_8) ? BEAT_W'(7) : BEAT_W'(3);
        last_o    = active_i && (cnt_i == final_idx);
    end
endmodule

// File: rtl/bsq_lane_mix.sv
module bsq_lane_mix
    import bsq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] cnt_i,
    input  blen_e             blen_i,
    input  order_e            order_i,
    output logic [COL_W-1:0]  col_o
);
    logic [OFS_W-1:0] ofs_sum;
    logic [OFS_W-1:0] ofs_out;

    assign ofs_sum = base_i[OFS_W-1:0] + OFS_W'(cnt_i);

    for (genvar k = 0; k < OFS_W; k++) begin : g_bit
        if (k < BL4_LOG) begin : g_always_in
            assign ofs_out[k] = (order_i == ORD_ILV) ? (base_i[k] ^ cnt_i[k]) : ofs_sum[k];
        end else begin : g_bl8_only
            logic in_blk;
            assign in_blk     = (blen_i == BLEN_8);
            assign ofs_out[k] = !in_blk ? base_i[k]
                              : ((order_i == ORD_ILV) ? (base_i[k] ^ cnt_i[k]) : ofs_sum[k]);
        end
    end

    assign col_o = {base_i[COL_W-1:OFS_W], ofs_out};
endmodule

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
    import bsq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic              bl8_i,
    input  logic              ilv_i,
    input  logic              rdy_i,
    input  logic              last_i,
    output logic              active_o,
    output logic [BEAT_W-1:0] cnt_o,
    output logic [COL_W-1:0]  base_o,
    output blen_e             blen_o,
    output order_e            order_o
);
    typedef struct packed {
        logic              active;
        blen_e             blen;
        order_e            order;
        logic [BEAT_W-1:0] cnt;
        logic [COL_W-1:0]  base;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
                st_d.base   = start_col_i;
                st_d.blen   = blen_e'(bl8_i);
                st_d.order  = order_e'(ilv_i);
            end
        end else if (rdy_i) begin
            if (last_i) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + BEAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign cnt_o    = st_q.cnt;
    assign base_o   = st_q.base;
    assign blen_o   = st_q.blen;
    assign order_o  = st_q.order;
endmodule

// File: rtl/bsq_burst_seq.sv
module bsq_burst_seq
    import bsq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             bl8_i,
    input  logic             ilv_i,
    input  logic             rdy_i,
    output logic [COL_W-1:0] col_o,
    output logic             vld_o,
    output logic [2:0]       beat_o,
    output logic             last_o
);
    logic              active_w;
    logic [BEAT_W-1:0] cnt_w;
    logic [COL_W-1:0]  base_w;
    blen_e             blen_w;
    order_e            order_w;
    logic              last_w;

    bsq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .bl8_i       (bl8_i),
        .ilv_i       (ilv_i),
        .rdy_i       (rdy_i),
        .last_i      (last_w),
        .active_o    (active_w),
        .cnt_o       (cnt_w),
        .base_o      (base_w),
        .blen_o      (blen_w),
        .order_o     (order_w)
    );

    bsq_last_det u_last (
        .active_i (active_w),
        .blen_i   (blen_w),
        .cnt_i    (cnt_w),
        .last_o   (last_w)
    );

    bsq_lane_mix #(.COL_W(COL_W)) u_mix (
        .base_i  (base_w),
        .cnt_i   (cnt_w),
        .blen_i  (blen_w),
        .order_i (order_w),
        .col_o   (col_o)
    );

    assign vld_o  = active_w;
    assign beat_o = 3'(cnt_w);
    assign last_o = last_w;
endmodule

// File: rtl/bsq_burst_seq_chk.sv
module bsq_burst_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             rdy_i,
    input logic [COL_W-1:0] col_o,
    input logic             vld_o,
    input logic [2:0]       beat_o,
    input logic             last_o,
    input logic             blen8_q
);
    AST_CRIT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!vld_o && start_i) |=> (vld_o && beat_o == 3'd0 && col_o == $past(start_col_i))); // R1
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (vld_o && $past(vld_o) && !$past(rst)) |-> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]))); // R3
    AST_LAST_POS: assert property (@(posedge clk) disable iff (rst)
        (vld_o && last_o) |-> (beat_o == (blen8_q ? 3'd7 : 3'd3))); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !rdy_i) |=> (vld_o && $stable(col_o) && $stable(beat_o))); // R6
    AST_STEP_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (vld_o && rdy_i && !last_o) |=> (vld_o && beat_o == $past(beat_o) + 3'd1)); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (vld_o && rdy_i && last_o) |=> !vld_o); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !vld_o |-> (!last_o && beat_o == 3'd0)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!vld_o && beat_o == 3'd0)); // R8
endmodule

bind bsq_burst_seq bsq_burst_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .rdy_i       (rdy_i),
    .col_o       (col_o),
    .vld_o       (vld_o),
    .beat_o      (beat_o),
    .last_o      (last_o),
    .blen8_q     (blen_w == bsq_pkg::BLEN_8)
);

// File: tb/tb_bsq_burst_seq.sv
`timescale 1ns/1ps
module tb_bsq_burst_seq;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             bl8_i = 1'b0;
    logic             ilv_i = 1'b0;
    logic             rdy_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             vld_o;
    logic [2:0]       beat_o;
    logic             last_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int stall_pct = 40;
    bit done = 1'b0;

    typedef struct {
        logic [COL_W-1:0] col;
        logic [2:0]       beat;
        logic             last;
        bit               ilv;
    } beat_t;
    beat_t exp_q[$];

    always #4 clk = ~clk;

    bsq_burst_seq #(.COL_W(COL_W)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .bl8_i(bl8_i), .ilv_i(ilv_i), .rdy_i(rdy_i),
        .col_o(col_o), .vld_o(vld_o), .beat_o(beat_o), .last_o(last_o)
    );

    // monitor: compare visible beat, then choose ready for the coming edge
    always @(negedge clk) begin
        cycles++;
        if (!rst && vld_o) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R7: unexpected beat col=%0d beat=%0d, expected none", col_o, beat_o);
            end else begin
                if (col_o !== exp_q[0].col || beat_o !== exp_q[0].beat || last_o !== exp_q[0].last) begin
                    bad++;
                    $display("FAIL %s/R3/R5/R6: col=%0d beat=%0d last=%0b, expected col=%0d beat=%0d last=%0b",
                             exp_q[0].ilv ? "R4" : "R2", col_o, beat_o, last_o,
                             exp_q[0].col, exp_q[0].beat, exp_q[0].last);
                end
                rdy_i = ($urandom_range(99) >= stall_pct);
                if (rdy_i) void'(exp_q.pop_front());
            end
        end else begin
            rdy_i = ($urandom_range(1) == 1);
        end
    end

    task automatic check(input string req, input logic cond, input int act, input int expv);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // driver: wait for idle, issue a start and push the expected beats
    task automatic issue(input logic [COL_W-1:0] s, input bit b8, input bit il, input bit poke);
        int bl = b8 ? 8 : 4;
        logic [COL_W-1:0] m = b8 ? COL_W'(7) : COL_W'(3);
        do @(negedge clk); while (vld_o || exp_q.size() != 0);
        start_i = 1'b1; start_col_i = s; bl8_i = b8; ilv_i = il;
        for (int i = 0; i < bl; i++) begin
            beat_t e;
            e.col  = il ? (s ^ COL_W'(i)) : ((s & ~m) | ((s + COL_W'(i)) & m));
            e.beat = 3'(i);
            e.last = (i == bl - 1);
            e.ilv  = il;
            exp_q.push_back(e);
        end
        @(negedge clk);
        if (poke) begin
            // R7: start and mode changes during a burst are ignored
            start_i = 1'b1; start_col_i = ~s; bl8_i = ~b8; ilv_i = ~il;
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        start_i = 1'b1; start_col_i = COL_W'(5);
        repeat (3) @(negedge clk);
        check("R8", vld_o == 1'b0, vld_o, 0);
        check("R8", beat_o == 3'd0, beat_o, 0);
        check("R8", last_o == 1'b0, last_o, 0);
        start_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R8", vld_o == 1'b0, vld_o, 0);

        // documented example orders (start 5), no stalls first
        stall_pct = 0;
        issue(COL_W'(5), 1'b0, 1'b0, 1'b0);
        issue(COL_W'(5), 1'b0, 1'b1, 1'b0);
        issue(COL_W'(5), 1'b1, 1'b0, 1'b0);
        issue(COL_W'(5), 1'b1, 1'b1, 1'b0);

        // every offset, both lengths and orders, random stalls (R1..R6)
        stall_pct = 40;
        for (int b = 0; b < 2; b++)
            for (int o = 0; o < 2; o++)
                for (int off = 0; off < 8; off++) begin
                    logic [COL_W-1:0] up = COL_W'($urandom_range(127));
                    issue((up << 3) | COL_W'(off), b[0], o[0], off[0]);
                end

        // upper bits all ones: carry out of the offset must be dropped (R3)
        for (int off = 0; off < 8; off++) begin
            issue({{(COL_W-3){1'b1}}, 3'(off)}, 1'b1, 1'b0, 1'b0);
            issue({{(COL_W-3){1'b1}}, 3'(off)}, 1'b0, 1'b0, 1'b1);
        end

        // heavy stalls
        stall_pct = 85;
        for (int k = 0; k < 6; k++)
            issue(COL_W'($urandom_range(1023)), k[0], k[1], 1'b1);

        do @(negedge clk); while (vld_o || exp_q.size() != 0);
        @(negedge clk);
        check("R7", vld_o == 1'b0, vld_o, 0);
        done = 1'b1;
    end

    initial begin
        wait (done || cycles > 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule